// File: doc/BRIEF.md
# Converter Fault Latch and Output Discharge Controller

This block gathers the qualified fault conditions of a synchronous buck converter into one sticky fault latch. It then drives the three signals that follow from the latch: a force-on request for the low-side switch that drains the output, an enable for a discharge resistor, and the power-good flag. All inputs are digital. They are comparator outputs that already sit in the block's clock domain, a one-cycle switching-clock tick, the enable and suspend controls, and an over-current request from the pulse-skipping logic.

Each fault source is qualified in its own way. Undervoltage and feedback-short faults must persist for a number of system-clock cycles set by parameters. Overvoltage must persist for a count of switching ticks. The high-side and over-current requests act at once. Sources also differ in whether they are masked while soft start is still below its low threshold. Once the latch is set, the low-side switch is pulsed with hysteresis against two output-voltage thresholds. This discharges the output without driving it negative. Only a reset or a low level on enable clears the latch.

Top module: `fault_latch_ctl`

## Requirements
- R1: With `en` high and `ss_low` low, `fb_uv` held high for `UV_QUAL` consecutive clock edges sets `fault_latched` after the last of those edges. Any edge where it is low restarts the count, so `UV_QUAL-1` edges followed by a low cycle leave the latch clear.
- R2: While `ss_low` is high, `fb_uv` has no effect on the latch and its qualification count is held at zero.
- R3: With `en` high, `fb_ov` high across `OV_TICKS` consecutive `sw_tick` pulses sets the latch at the edge carrying the last pulse. Edges without a tick keep the count, and any edge with `fb_ov` low restarts it. This applies whatever the level of `ss_low`.
- R4: With `en` high, `hs_fault` high at a clock edge sets the latch at that edge, including while `ss_low` is high.
- R5: With `en` high, the feedback-short condition (`out_gt_1v`, `fb_near_zero` and `ss_low` all high) held for more than `FBS_QUAL` consecutive edges sets the latch. Holding it for exactly `FBS_QUAL` edges and then dropping it does not.
- R6: With `en` high, `oc_fault` high at an edge sets the latch only when `ss_low` is low at that edge.
- R7: The latch stays set while `en` stays high. Any edge with `en` low clears it, restarts all qualification counts, and blocks every fault source. After reset the latch is clear.
- R8: `ls_force` is high only while the latch is set. It starts high when the latch sets. It goes low at the edge after it has seen `out_lt_0v5` high, and goes high again at the edge after it has seen `out_gt_0v8` high while low.
- R9: `dis_en` is high whenever the latch is set or `en` is low, and low otherwise.
- R10: `pgood` is high only when `suspend_n`, `ss_gt_4v`, `fb_in_window` and `aux_ok` are all high and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power cycle) |
| en | input | 1 | Converter enable; low clears the latch |
| suspend_n | input | 1 | High when the system is in the full-on state |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| fb_uv | input | 1 | Feedback below the undervoltage threshold |
| fb_ov | input | 1 | Feedback above the overvoltage threshold |
| hs_fault | input | 1 | High-side fault sample result |
| fb_near_zero | input | 1 | Feedback below about 100 mV |
| out_gt_1v | input | 1 | Output above 1 V |
| out_lt_0v5 | input | 1 | Output below 0.5 V |
| out_gt_0v8 | input | 1 | Output above 0.8 V |
| ss_low | input | 1 | Soft-start voltage below 1.3 V |
| ss_gt_4v | input | 1 | Soft-start voltage above 4 V |
| fb_in_window | input | 1 | Feedback within 90 % to 110 % of reference |
| aux_ok | input | 1 | Auxiliary linear rails in regulation |
| oc_fault | input | 1 | Qualified over-current fault request |
| fault_latched | output | 1 | Sticky fault latch state |
| ls_force | output | 1 | Forces the low-side switch on for discharge |
| dis_en | output | 1 | Enables the output discharge resistor |
| pgood | output | 1 | Power good |

## Verification
On every cycle the assertions check several properties. They check that the latch holds under a steady enable and clears under a low one, and that the immediate sources (high-side fault, and over-current outside soft start) set it. They also check that the discharge pulse exists only inside a fault and releases after the low threshold, and that power good never coexists with a fault or with suspend. The qualification windows need the bench's scenarios and its cycle-accurate model. Those windows are the undervoltage and feedback-short cycle counts at their exact boundaries, restart on a dropped condition, tick counting for overvoltage, and the soft-start masking of each source.

// File: rtl/fault_latch_ctl.sv
module fault_latch_ctl #(
  parameter int UV_QUAL  = 250,
  parameter int FBS_QUAL = 1750,
  parameter int OV_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic suspend_n,
  input  logic sw_tick,
  input  logic fb_uv,
  input  logic fb_ov,
  input  logic hs_fault,
  input  logic fb_near_zero,
  input  logic out_gt_1v,
  input  logic out_lt_0v5,
  input  logic out_gt_0v8,
  input  logic ss_low,
  input  logic ss_gt_4v,
  input  logic fb_in_window,
  input  logic aux_ok,
  input  logic oc_fault,
  output logic fault_latched,
  output logic ls_force,
  output logic dis_en,
  output logic pgood
);

  localparam int UVW = $clog2(UV_QUAL + 1);
  localparam int FBW = $clog2(FBS_QUAL + 2);
  localparam int OVW = $clog2(OV_TICKS + 1);
  localparam logic [UVW-1:0] UV_LAST = UVW'(UV_QUAL - 1);
  localparam logic [FBW-1:0] FB_LAST = FBW'(FBS_QUAL);
  localparam logic [OVW-1:0] OV_LAST = OVW'(OV_TICKS - 1);

  logic [UVW-1:0] uv_cnt;
  logic [FBW-1:0] fbs_cnt;
  logic [OVW-1:0] ov_cnt;
  logic           fault_q;
  logic           pulse_q;

  wire uv_cond  = fb_uv & ~ss_low;
  wire fbs_cond = out_gt_1v & fb_near_zero & ss_low;

  wire uv_hit  = uv_cond & (uv_cnt == UV_LAST);
  wire fbs_hit = fbs_cond & (fbs_cnt == FB_LAST);
  wire ov_hit  = fb_ov & sw_tick & (ov_cnt == OV_LAST);
  wire oc_hit  = oc_fault & ~ss_low;
  wire any_hit = uv_hit | fbs_hit | ov_hit | hs_fault | oc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_cnt <= '0;
    end else if (!en || !uv_cond) begin
      uv_cnt <= '0;
    end else if (uv_cnt != UV_LAST) begin
      uv_cnt <= uv_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbs_cnt <= '0;
    end else if (!en || !fbs_cond) begin
      fbs_cnt <= '0;
    end else if (fbs_cnt != FB_LAST) begin
      fbs_cnt <= fbs_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_cnt <= '0;
    end else if (!en || !fb_ov) begin
      ov_cnt <= '0;
    end else if (sw_tick && ov_cnt != OV_LAST) begin
      ov_cnt <= ov_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (!en) begin
      fault_q <= 1'b0;
    end else if (any_hit) begin
      fault_q <= 1'b1;
    end
  end

  // hysteretic discharge: drain until below 0.5 V, rest until above 0.8 V
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b1;
    end else if (!fault_q) begin
      pulse_q <= 1'b1;
    end else if (pulse_q && out_lt_0v5) begin
      pulse_q <= 1'b0;
    end else if (!pulse_q && out_gt_0v8) begin
      pulse_q <= 1'b1;
    end
  end

  assign fault_latched = fault_q;
  assign ls_force      = fault_q & pulse_q;
  assign dis_en        = fault_q | ~en;
  assign pgood         = suspend_n & ss_gt_4v & ~fault_q & fb_in_window & aux_ok;

endmodule

// File: rtl/fault_latch_chk.sv
module fault_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic suspend_n,
  input logic hs_fault,
  input logic out_lt_0v5,
  input logic ss_low,
  input logic ss_gt_4v,
  input logic oc_fault,
  input logic fault_latched,
  input logic ls_force,
  input logic dis_en,
  input logic pgood
);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && en) |=> fault_latched);

  // R7
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fault_latched);

  // R4
  hs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hs_fault) |=> fault_latched);

  // R6
  oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && oc_fault && !ss_low) |=> fault_latched);

  // R8
  ls_in_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_force |-> fault_latched);

  // R8
  ls_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_force && out_lt_0v5) |=> !ls_force);

  // R9
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || fault_latched) |-> dis_en);

  // R10
  pg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (!fault_latched && suspend_n && ss_gt_4v));

endmodule

bind fault_latch_ctl fault_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .suspend_n(suspend_n),
  .hs_fault(hs_fault), .out_lt_0v5(out_lt_0v5), .ss_low(ss_low),
  .ss_gt_4v(ss_gt_4v), .oc_fault(oc_fault),
  .fault_latched(fault_latched), .ls_force(ls_force),
  .dis_en(dis_en), .pgood(pgood)
);

// File: tb/fault_latch_ctl_test.sv
`timescale 1ns/1ps
module fault_latch_ctl_test;
  localparam int UVQ = 250;
  localparam int FBQ = 1750;
  localparam int OVT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, suspend_n = 0, sw_tick = 0, fb_uv = 0, fb_ov = 0, hs_fault = 0;
  logic fb_near_zero = 0, out_gt_1v = 0, out_lt_0v5 = 0, out_gt_0v8 = 0;
  logic ss_low = 1, ss_gt_4v = 0, fb_in_window = 0, aux_ok = 0, oc_fault = 0;
  logic fault_latched, ls_force, dis_en, pgood;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_latch_ctl #(.UV_QUAL(UVQ), .FBS_QUAL(FBQ), .OV_TICKS(OVT)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .suspend_n(suspend_n), .sw_tick(sw_tick),
    .fb_uv(fb_uv), .fb_ov(fb_ov), .hs_fault(hs_fault), .fb_near_zero(fb_near_zero),
    .out_gt_1v(out_gt_1v), .out_lt_0v5(out_lt_0v5), .out_gt_0v8(out_gt_0v8),
    .ss_low(ss_low), .ss_gt_4v(ss_gt_4v), .fb_in_window(fb_in_window),
    .aux_ok(aux_ok), .oc_fault(oc_fault), .fault_latched(fault_latched),
    .ls_force(ls_force), .dis_en(dis_en), .pgood(pgood)
  );

  // behavioural reference: run lengths per fault source
  bit m_lat = 0;
  bit m_drain = 1;
  int uv_run = 0, ov_run = 0, fb_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 0; m_drain = 1; uv_run = 0; ov_run = 0; fb_run = 0;
    end else if (!en) begin
      m_lat = 0; m_drain = 1; uv_run = 0; ov_run = 0; fb_run = 0;
    end else begin
      bit trip;
      trip = 0;
      if (fb_uv && !ss_low) begin
        uv_run++;
        if (uv_run >= UVQ) trip = 1;
      end else uv_run = 0;
      if (fb_ov) begin
        if (sw_tick) ov_run++;
        if (sw_tick && ov_run >= OVT) trip = 1;
      end else ov_run = 0;
      if (out_gt_1v && fb_near_zero && ss_low) begin
        fb_run++;
        if (fb_run > FBQ) trip = 1;
      end else fb_run = 0;
      if (hs_fault) trip = 1;
      if (oc_fault && !ss_low) trip = 1;
      if (!m_lat) m_drain = 1;
      else if (m_drain && out_lt_0v5) m_drain = 0;
      else if (!m_drain && out_gt_0v8) m_drain = 1;
      if (trip) m_lat = 1;
    end
  end

  task automatic cmp(string tag, string nm, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R7", "fault_latched", fault_latched, m_lat);
      cmp("R8", "ls_force", ls_force, m_lat & m_drain);
      cmp("R9", "dis_en", dis_en, m_lat | ~en);
      cmp("R10", "pgood", pgood, suspend_n & ss_gt_4v & ~m_lat & fb_in_window & aux_ok);
    end
  end

  task automatic sync();
    @(posedge clk); #2;
  endtask
  task automatic tick(int n);
    repeat (n) sync();
  endtask
  task automatic probe();
    @(negedge clk);
  endtask
  task automatic clear_fault();
    en = 0; sync(); probe();
    cmp("R7", "cleared by enable low", fault_latched, 1'b0);
    cmp("R9", "dis_en with enable low", dis_en, 1'b1);
    en = 1; sync();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    probe();
    cmp("R7", "reset fault", fault_latched, 1'b0);
    cmp("R8", "reset ls_force", ls_force, 1'b0);
    cmp("R10", "reset pgood", pgood, 1'b0);
    sync(); rst_n = 1; sync();
    probe();
    cmp("R9", "dis_en disabled", dis_en, 1'b1);
    en = 1; sync(); probe();
    cmp("R9", "dis_en enabled", dis_en, 1'b0);

    // R10 power good gating
    suspend_n = 1; ss_gt_4v = 1; fb_in_window = 1; aux_ok = 1; ss_low = 0;
    sync(); probe();
    cmp("R10", "pgood all met", pgood, 1'b1);
    suspend_n = 0; sync(); probe();
    cmp("R10", "pgood suspend", pgood, 1'b0);
    suspend_n = 1; aux_ok = 0; sync(); probe();
    cmp("R10", "pgood aux", pgood, 1'b0);
    aux_ok = 1; fb_in_window = 0; sync(); probe();
    cmp("R10", "pgood window", pgood, 1'b0);
    fb_in_window = 1; sync();

    // R2 masked undervoltage
    ss_low = 1; fb_uv = 1; tick(UVQ + 100); probe();
    cmp("R2", "uv masked in soft start", fault_latched, 1'b0);
    sync(); ss_low = 0; fb_uv = 0; sync();

    // R1 boundary and restart
    fb_uv = 1; tick(UVQ - 1); fb_uv = 0; probe();
    cmp("R1", "uv one short", fault_latched, 1'b0);
    sync(); fb_uv = 1; tick(UVQ - 1); probe();
    cmp("R1", "uv before last edge", fault_latched, 1'b0);
    sync(); probe();
    cmp("R1", "uv qualified", fault_latched, 1'b1);
    cmp("R10", "pgood dropped on fault", pgood, 1'b0);
    fb_uv = 0;

    // R8 hysteretic discharge
    cmp("R8", "drain starts on", ls_force, 1'b1);
    out_lt_0v5 = 1; sync(); probe();
    cmp("R8", "drain released", ls_force, 1'b0);
    sync(); out_lt_0v5 = 0; tick(3); probe();
    cmp("R8", "stays released between thresholds", ls_force, 1'b0);
    sync(); out_gt_0v8 = 1; sync(); probe();
    cmp("R8", "drain re-armed", ls_force, 1'b1);
    sync(); out_gt_0v8 = 0; tick(2);
    clear_fault();

    // R3 overvoltage tick counting with restart
    fb_ov = 1;
    for (int i = 0; i < OVT - 1; i++) begin
      sw_tick = 1; sync(); sw_tick = 0; tick(3);
    end
    probe();
    cmp("R3", "ov one tick short", fault_latched, 1'b0);
    sync(); fb_ov = 0; sync(); fb_ov = 1;
    for (int i = 0; i < OVT - 1; i++) begin
      sw_tick = 1; sync(); sw_tick = 0; tick(2);
    end
    probe();
    cmp("R3", "ov restarted", fault_latched, 1'b0);
    sync(); ss_low = 1; sw_tick = 1; sync(); sw_tick = 0; probe();
    cmp("R3", "ov qualified in soft start", fault_latched, 1'b1);
    fb_ov = 0; sync();
    clear_fault();

    // R4 high-side fault during soft start
    hs_fault = 1; sync(); hs_fault = 0; probe();
    cmp("R4", "hs fault sets latch", fault_latched, 1'b1);
    sync(); tick(5); probe();
    cmp("R7", "latch sticky", fault_latched, 1'b1);
    sync(); clear_fault();

    // R5 feedback short boundary
    out_gt_1v = 1; fb_near_zero = 1;
    tick(FBQ); out_gt_1v = 0; probe();
    cmp("R5", "short exactly window", fault_latched, 1'b0);
    sync(); out_gt_1v = 1; tick(FBQ); probe();
    cmp("R5", "short at window", fault_latched, 1'b0);
    sync(); probe();
    cmp("R5", "short beyond window", fault_latched, 1'b1);
    out_gt_1v = 0; fb_near_zero = 0; sync();
    clear_fault();

    // R6 over-current masking
    oc_fault = 1; sync(); oc_fault = 0; probe();
    cmp("R6", "oc masked in soft start", fault_latched, 1'b0);
    sync(); ss_low = 0; oc_fault = 1; sync(); oc_fault = 0; probe();
    cmp("R6", "oc sets latch", fault_latched, 1'b1);

    // R7 no set while disabled
    sync(); en = 0; hs_fault = 1; tick(2); probe();
    cmp("R7", "disabled blocks faults", fault_latched, 1'b0);
    sync(); hs_fault = 0; en = 1; tick(3); probe();
    cmp("R7", "stays clear after re-enable", fault_latched, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule